// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a target programmable device through its slave-serial configuration port. On a start pulse it runs the whole load. It asserts the target's program line and waits for the target's init line to fall. It then releases program and waits for init to rise. Next it shifts a byte stream into the target, most significant bit first, with a software-free clock and data pattern. Finally it waits for the target's done line.

The bytes arrive on a valid/ready stream with a last flag. Bytes ahead of the sync run (four consecutive 0xFF bytes) are consumed and dropped. The sync run and everything after it are shifted out. A millisecond tick input paces the three waits. Each wait gives up after a fixed number of ticks and reports its own error code. The result, success or one error code, is held until the next start.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, program is at its inactive level, the serial clock and data outputs are high, busy is 0, done_ok is 0 and err_code is 0.
- R2: A start pulse while idle clears done_ok and err_code. In the next cycle it raises busy and drives program to its active level. The polarity is set by PROG_ACTIVE_HIGH, and the default of 0 means active low.
- R3: When init is seen low while program is active, program returns to its inactive level in the next cycle. The block then waits for init high before it accepts any stream byte.
- R4: In each wait, every ms_tick pulse during which the awaited level is absent is counted. Four such ticks are tolerated. The fifth (POLL_LIMIT+2) ends the load with an error.
- R5: The error codes are: 1 when init never fell after program was asserted, 2 when init never rose after program was released, and 3 when done never rose after the data. busy drops in the same cycle that the code appears, and an error never coexists with done_ok.
- R6: Stream bytes received before the first run of four consecutive 0xFF bytes are consumed and not shifted out. That run and all following bytes are shifted out.
- R7: Each shifted byte produces exactly eight data bits, most significant bit first, sampled by the target on the rising serial clock.
- R8: Each bit takes four steps of STEP_CLKS cycles each: clock low with data high, clock low with data at the bit, clock high with data at the bit, and clock high with data high.
- R9: Program is at its inactive level whenever the serial clock toggles.
- R10: The done wait starts after the final bit of the byte marked last. It also starts when a last byte arrives before the sync run was found. A high done level then sets done_ok and clears busy in the next cycle.
- R11: done_ok and err_code keep their values until the next start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (one-cycle pulse, accepted when idle) |
| ms_tick | input | 1 | One-cycle pulse per millisecond for the waits |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| cfg_prog | output | 1 | Program line to the target |
| cfg_clk | output | 1 | Serial configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init | input | 1 | Init line from the target |
| cfg_done | input | 1 | Done line from the target |
| busy | output | 1 | A load is in progress |
| done_ok | output | 1 | The last load finished with done high |
| err_code | output | 2 | 0 none, 1/2/3 per R5 |

## Verification
Start raises busy and program one cycle after it is sampled, and program is released one cycle after init low is sampled. An error or done_ok appears one cycle after the deciding tick or done level. The bench drives all inputs on the falling clock edge and checks outputs at the next falling edge, half a cycle after the register that produces them. The serial output is not timed by absolute cycle. The bench captures data on every rising serial clock and compares the collected bits with a list built from the stimulus. Step lengths and the clock/data ordering are checked on each serial clock edge.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_INIT_LOW,
        SEQ_INIT_HIGH,
        SEQ_SHIFT,
        SEQ_DONE_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE         = 2'd0,
        ERR_INIT_NO_FALL = 2'd1,
        ERR_INIT_NO_RISE = 2'd2,
        ERR_DONE_MISSING = 2'd3
    } err_code_e;

    typedef enum logic [1:0] {
        STEP_LEAD,
        STEP_SETUP,
        STEP_HOLD,
        STEP_TRAIL
    } bit_step_e;

    typedef struct packed {
        logic clk;
        logic din;
    } pin_pair_t;

    localparam pin_pair_t PINS_REST = '{clk: 1'b1, din: 1'b1};

    // Pin levels for one of the four steps of a serial bit.
    function automatic pin_pair_t step_pins(bit_step_e s, logic b);
        pin_pair_t p;
        case (s)
            STEP_LEAD:  p = '{clk: 1'b0, din: 1'b1};
            STEP_SETUP: p = '{clk: 1'b0, din: b};
            STEP_HOLD:  p = '{clk: 1'b1, din: b};
            default:    p = '{clk: 1'b1, din: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfgld_poll_timer.sv
module cfgld_poll_timer #(
    parameter int POLL_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    input  logic waiting,
    output logic expire
);
    localparam int MAXC = POLL_LIMIT + 1;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    assign expire = tick && waiting && (cnt_q == CW'(MAXC));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick && waiting && (cnt_q != CW'(MAXC))) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAXC));

endmodule

// File: rtl/cfgld_preamble_hunt.sv
module cfgld_preamble_hunt #(
    parameter int SYNC_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       enable,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output logic       s_ready,
    output logic       b_valid,
    output logic [7:0] b_data,
    output logic       b_last,
    input  logic       b_ready,
    output logic       tail_nosync
);
    localparam int RW = $clog2(SYNC_LEN + 1);

    logic          locked_q;
    logic [RW-1:0] run_q;
    logic [RW-1:0] replay_q;
    logic          last_held_q;
    logic          is_ff;
    logic          completes;

    assign is_ff     = (s_data == 8'hFF);
    assign completes = is_ff && (run_q == RW'(SYNC_LEN - 1));

    always_comb begin
        s_ready     = 1'b0;
        b_valid     = 1'b0;
        b_data      = 8'hFF;
        b_last      = 1'b0;
        tail_nosync = 1'b0;
        if (!locked_q) begin
            s_ready     = enable;
            tail_nosync = enable && s_valid && s_last && !completes;
        end else if (replay_q != '0) begin
            b_valid = enable;
            b_last  = last_held_q && (replay_q == RW'(1));
        end else begin
            s_ready = enable && b_ready;
            b_valid = enable && s_valid;
            b_data  = s_data;
            b_last  = s_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            locked_q    <= 1'b0;
            run_q       <= '0;
            replay_q    <= '0;
            last_held_q <= 1'b0;
        end else if (!locked_q) begin
            if (enable && s_valid) begin
                if (completes) begin
                    locked_q    <= 1'b1;
                    replay_q    <= RW'(SYNC_LEN);
                    last_held_q <= s_last;
                    run_q       <= '0;
                end else if (is_ff) begin
                    run_q <= run_q + RW'(1);
                end else begin
                    run_q <= '0;
                end
            end
        end else if ((replay_q != '0) && b_valid && b_ready) begin
            replay_q <= replay_q - RW'(1);
        end
    end

    assert_lock_sticks_R6: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !arm) |=> locked_q);

    assert_no_output_before_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (!locked_q) |-> !b_valid);

endmodule

// File: rtl/cfgld_bit_shifter.sv
module cfgld_bit_shifter
    import cfgld_pkg::*;
#(
    parameter int STEP_CLKS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       b_valid,
    input  logic [7:0] b_data,
    input  logic       b_last,
    output logic       b_ready,
    output logic       cfg_clk,
    output logic       cfg_din,
    output logic       tail_sent
);
    localparam int DW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;

    logic          active_q;
    logic [7:0]    shreg_q;
    logic [2:0]    bitn_q;
    bit_step_e     step_q;
    logic [DW-1:0] dwell_q;
    logic          last_q;
    logic          dwell_end;
    pin_pair_t     pins;

    assign dwell_end = (dwell_q == DW'(STEP_CLKS - 1));
    assign b_ready   = !active_q;
    assign tail_sent = active_q && dwell_end && (step_q == STEP_TRAIL)
                       && (bitn_q == 3'd0) && last_q;

    always_comb begin
        pins = active_q ? step_pins(step_q, shreg_q[7]) : PINS_REST;
    end

    assign cfg_clk = pins.clk;
    assign cfg_din = pins.din;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            shreg_q  <= '0;
            bitn_q   <= '0;
            step_q   <= STEP_LEAD;
            dwell_q  <= '0;
            last_q   <= 1'b0;
        end else if (!active_q) begin
            if (b_valid) begin
                active_q <= 1'b1;
                shreg_q  <= b_data;
                bitn_q   <= 3'd7;
                step_q   <= STEP_LEAD;
                dwell_q  <= '0;
                last_q   <= b_last;
            end
        end else if (!dwell_end) begin
            dwell_q <= dwell_q + DW'(1);
        end else begin
            dwell_q <= '0;
            if (step_q == STEP_TRAIL) begin
                step_q <= STEP_LEAD;
                if (bitn_q == 3'd0) begin
                    active_q <= 1'b0;
                end else begin
                    bitn_q  <= bitn_q - 3'd1;
                    shreg_q <= {shreg_q[6:0], 1'b0};
                end
            end else begin
                step_q <= bit_step_e'(step_q + 2'd1);
            end
        end
    end

    assert_clk_fall_data_high_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_clk) |-> (cfg_din && $past(cfg_din)));

    assert_data_steady_at_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_clk) |-> $stable(cfg_din));

    assert_data_falls_with_clk_low_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_din) |-> !cfg_clk);

    assert_accept_starts_shift_R7: assert property (@(posedge clk) disable iff (rst)
        (b_valid && b_ready) |=> !cfg_clk);

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfgld_pkg::*;
#(
    parameter bit PROG_ACTIVE_HIGH = 1'b0,
    parameter int STEP_CLKS        = 1,
    parameter int POLL_LIMIT       = 3,
    parameter int SYNC_LEN         = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       ms_tick,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output logic       s_ready,
    output logic       cfg_prog,
    output logic       cfg_clk,
    output logic       cfg_din,
    input  logic       cfg_init,
    input  logic       cfg_done,
    output logic       busy,
    output logic       done_ok,
    output logic [1:0] err_code
);
    localparam logic PROG_ON_LVL  = PROG_ACTIVE_HIGH;
    localparam logic PROG_OFF_LVL = !PROG_ACTIVE_HIGH;

    seq_state_e state_q, state_d;
    err_code_e  err_q, err_d;
    logic       ok_q, ok_d;
    logic       go;
    logic       waiting;
    logic       expire;
    logic       timer_clr;
    logic       tail_sent;
    logic       tail_nosync;
    logic       b_valid, b_last, b_ready;
    logic [7:0] b_data;

    assign go = (state_q == SEQ_IDLE) && start;

    always_comb begin
        waiting = 1'b0;
        case (state_q)
            SEQ_INIT_LOW:  waiting = cfg_init;
            SEQ_INIT_HIGH: waiting = !cfg_init;
            SEQ_DONE_WAIT: waiting = !cfg_done;
            default:       waiting = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        ok_d    = ok_q;
        case (state_q)
            SEQ_IDLE: begin
                if (start) begin
                    state_d = SEQ_INIT_LOW;
                    err_d   = ERR_NONE;
                    ok_d    = 1'b0;
                end
            end
            SEQ_INIT_LOW: begin
                if (!cfg_init) begin
                    state_d = SEQ_INIT_HIGH;
                end else if (expire) begin
                    state_d = SEQ_IDLE;
                    err_d   = ERR_INIT_NO_FALL;
                end
            end
            SEQ_INIT_HIGH: begin
                if (cfg_init) begin
                    state_d = SEQ_SHIFT;
                end else if (expire) begin
                    state_d = SEQ_IDLE;
                    err_d   = ERR_INIT_NO_RISE;
                end
            end
            SEQ_SHIFT: begin
                if (tail_sent || tail_nosync) begin
                    state_d = SEQ_DONE_WAIT;
                end
            end
            SEQ_DONE_WAIT: begin
                if (cfg_done) begin
                    state_d = SEQ_IDLE;
                    ok_d    = 1'b1;
                end else if (expire) begin
                    state_d = SEQ_IDLE;
                    err_d   = ERR_DONE_MISSING;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    assign timer_clr = (state_q == SEQ_IDLE) || (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            err_q   <= ERR_NONE;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            ok_q    <= ok_d;
        end
    end

    assign busy     = (state_q != SEQ_IDLE);
    assign done_ok  = ok_q;
    assign err_code = err_q;
    assign cfg_prog = (state_q == SEQ_INIT_LOW) ? PROG_ON_LVL : PROG_OFF_LVL;

    cfgld_poll_timer #(
        .POLL_LIMIT(POLL_LIMIT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (timer_clr),
        .tick   (ms_tick),
        .waiting(waiting),
        .expire (expire)
    );

    cfgld_preamble_hunt #(
        .SYNC_LEN(SYNC_LEN)
    ) u_hunt (
        .clk        (clk),
        .rst        (rst),
        .arm        (go),
        .enable     (state_q == SEQ_SHIFT),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_last     (s_last),
        .s_ready    (s_ready),
        .b_valid    (b_valid),
        .b_data     (b_data),
        .b_last     (b_last),
        .b_ready    (b_ready),
        .tail_nosync(tail_nosync)
    );

    cfgld_bit_shifter #(
        .STEP_CLKS(STEP_CLKS)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .b_valid  (b_valid),
        .b_data   (b_data),
        .b_last   (b_last),
        .b_ready  (b_ready),
        .cfg_clk  (cfg_clk),
        .cfg_din  (cfg_din),
        .tail_sent(tail_sent)
    );

    assert_start_enters_reset_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && (cfg_prog == PROG_ON_LVL)));

    assert_busy_fall_has_result_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done_ok || (err_code != 2'd0)));

    assert_result_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(done_ok && (err_code != 2'd0)));

    assert_prog_off_while_clocking_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(cfg_clk) || $rose(cfg_clk)) |-> (cfg_prog == PROG_OFF_LVL));

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(err_code) && $stable(done_ok)));

    assert_no_stream_before_init_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_INIT_LOW || state_q == SEQ_INIT_HIGH) |-> !s_ready);

endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       ms_tick = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       cfg_prog, cfg_clk, cfg_din;
    logic       cfg_init = 1'b1;
    logic       cfg_done = 1'b0;
    logic       busy, done_ok;
    logic [1:0] err_code;

    localparam int STEP = 1;

    int checks = 0;
    int errors = 0;

    logic [7:0] stim [0:63];
    int         nstim = 0;
    bit         exp_bits[$];
    bit         got_bits[$];
    int         pat_err = 0;
    int         prog_err = 0;
    int         low_run = 0;
    logic       prev_clk = 1'b1;
    logic       prev_din = 1'b1;

    always #5 clk = ~clk;

    serial_cfg_loader u_dut (
        .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .cfg_prog(cfg_prog), .cfg_clk(cfg_clk), .cfg_din(cfg_din),
        .cfg_init(cfg_init), .cfg_done(cfg_done),
        .busy(busy), .done_ok(done_ok), .err_code(err_code)
    );

    // Serial pin monitor: capture on rising serial clock, check the step pattern.
    always @(negedge clk) begin
        if (rst) begin
            prev_clk <= 1'b1;
            prev_din <= 1'b1;
            low_run  <= 0;
        end else begin
            if (!prev_clk && cfg_clk) begin
                got_bits.push_back(cfg_din);
                if (low_run != 2 * STEP) pat_err <= pat_err + 1;
                if (prev_din != cfg_din) pat_err <= pat_err + 1;
            end
            if (prev_clk && !cfg_clk) begin
                low_run <= 1;
                if (!(prev_din && cfg_din)) pat_err <= pat_err + 1;
            end else if (!cfg_clk) begin
                low_run <= low_run + 1;
            end
            if (prev_clk != cfg_clk && cfg_prog != 1'b1) prog_err <= prog_err + 1;
            prev_clk <= cfg_clk;
            prev_din <= cfg_din;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    function automatic void push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_bits.push_back(b[i]);
    endfunction

    task automatic tick_once;
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(cfg_prog == 1'b0, "R2 program active", cfg_prog, 0);
        chk(err_code == 2'd0 && done_ok == 1'b0, "R2 results cleared", err_code, 0);
    endtask

    task automatic enter_shift;
        pulse_start();
        repeat (2) @(negedge clk);
        chk(s_ready == 1'b0, "R3 no stream before init", s_ready, 0);
        cfg_init = 1'b0;
        @(negedge clk);
        chk(cfg_prog == 1'b1, "R3 program released", cfg_prog, 1);
        repeat (2) @(negedge clk);
        cfg_init = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_stream;
        int idx = 0;
        while (idx < nstim) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = stim[idx];
            s_last  = (idx == nstim - 1);
            #1;
            if (s_ready) idx++;
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic wait_bits;
        int w = 0;
        while (got_bits.size() < exp_bits.size() && w < 4000) begin
            @(negedge clk);
            w++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic compare_bits(input string tag);
        int mism = -1;
        chk(got_bits.size() == exp_bits.size(), {tag, " R7 bit count"},
            got_bits.size(), exp_bits.size());
        for (int i = 0; i < exp_bits.size() && i < got_bits.size(); i++) begin
            if (mism < 0 && got_bits[i] != exp_bits[i]) mism = i;
        end
        chk(mism < 0, {tag, " R6 R7 first bit mismatch index"}, mism, -1);
    endtask

    task automatic finish_ok(input string tag);
        chk(busy == 1'b1 && done_ok == 1'b0, {tag, " R10 waiting for done"}, busy, 1);
        cfg_done = 1'b1;
        @(negedge clk);
        chk(done_ok == 1'b1 && busy == 1'b0, {tag, " R10 done_ok"}, done_ok, 1);
        chk(err_code == 2'd0, {tag, " R5 no error on success"}, err_code, 0);
        cfg_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_lists;
        exp_bits.delete();
        got_bits.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cfg_prog == 1'b1 && cfg_clk == 1'b1 && cfg_din == 1'b1, "R1 idle pins",
            {cfg_prog, cfg_clk, cfg_din}, 7);
        chk(busy == 1'b0 && done_ok == 1'b0 && err_code == 2'd0, "R1 idle results",
            {busy, done_ok, err_code}, 0);

        // Directed: junk with a short 0xFF run before the sync run.
        clear_lists();
        stim[0] = 8'h00; stim[1] = 8'hFF; stim[2] = 8'hFF; stim[3] = 8'hFF;
        stim[4] = 8'h12; stim[5] = 8'hFF; stim[6] = 8'hFF; stim[7] = 8'hFF;
        stim[8] = 8'hFF; stim[9] = 8'hA5; stim[10] = 8'h3C;
        nstim = 11;
        for (int i = 5; i < 11; i++) push_byte(stim[i]);
        enter_shift();
        send_stream();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R11 start while busy ignored", busy, 1);
        wait_bits();
        compare_bits("directed");
        finish_ok("directed");
        chk(pat_err == 0, "R8 four-step pattern", pat_err, 0);
        chk(prog_err == 0, "R9 program idle while clocking", prog_err, 0);

        // Random payloads behind a random junk prefix.
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h5EED);
        end
        for (int it = 0; it < 3; it++) begin
            int nj, np;
            clear_lists();
            nj = $urandom_range(0, 5);
            np = $urandom_range(1, 8);
            nstim = 0;
            for (int j = 0; j < nj; j++) begin
                logic [7:0] b;
                b = 8'($urandom);
                if (b == 8'hFF) b = 8'h7E;
                stim[nstim] = b; nstim++;
            end
            for (int j = 0; j < 4; j++) begin
                stim[nstim] = 8'hFF; nstim++; push_byte(8'hFF);
            end
            for (int j = 0; j < np; j++) begin
                stim[nstim] = 8'($urandom); push_byte(stim[nstim]); nstim++;
            end
            enter_shift();
            send_stream();
            wait_bits();
            compare_bits("random");
            finish_ok("random");
        end

        // Sync run is the whole image and carries the last flag.
        clear_lists();
        for (int j = 0; j < 4; j++) begin stim[j] = 8'hFF; push_byte(8'hFF); end
        nstim = 4;
        enter_shift();
        send_stream();
        wait_bits();
        compare_bits("sync only");
        finish_ok("sync only");

        // No sync run: last byte ends the stream with nothing shifted.
        clear_lists();
        stim[0] = 8'h11; stim[1] = 8'hFF; stim[2] = 8'h22; nstim = 3;
        enter_shift();
        send_stream();
        repeat (4) @(negedge clk);
        chk(got_bits.size() == 0, "R6 R10 nothing shifted without sync", got_bits.size(), 0);
        finish_ok("no sync");

        // Error 1: init never falls.
        pulse_start();
        repeat (4) tick_once();
        chk(busy == 1'b1 && err_code == 2'd0, "R4 four ticks tolerated", err_code, 0);
        tick_once();
        chk(err_code == 2'd1, "R5 init no-fall code", err_code, 1);
        chk(busy == 1'b0 && cfg_prog == 1'b1, "R5 busy off program idle", busy, 0);
        cfg_init = 1'b0; cfg_done = 1'b1;
        repeat (2) tick_once();
        cfg_init = 1'b1; cfg_done = 1'b0;
        @(negedge clk);
        chk(err_code == 2'd1 && done_ok == 1'b0, "R11 error held", err_code, 1);

        // Error 2: init falls late (boundary), then never rises.
        pulse_start();
        chk(err_code == 2'd0, "R11 start clears error", err_code, 0);
        repeat (4) tick_once();
        cfg_init = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1 && cfg_prog == 1'b1, "R4 late init fall accepted", cfg_prog, 1);
        repeat (4) tick_once();
        chk(busy == 1'b1 && err_code == 2'd0, "R4 four ticks in init-high wait", err_code, 0);
        tick_once();
        chk(err_code == 2'd2 && busy == 1'b0, "R5 init no-rise code", err_code, 2);
        cfg_init = 1'b1;
        @(negedge clk);

        // Error 3: data sent, done never rises.
        clear_lists();
        for (int j = 0; j < 4; j++) begin stim[j] = 8'hFF; push_byte(8'hFF); end
        stim[4] = 8'h96; push_byte(8'h96); nstim = 5;
        enter_shift();
        send_stream();
        wait_bits();
        compare_bits("done timeout");
        repeat (4) tick_once();
        chk(busy == 1'b1 && err_code == 2'd0, "R4 four ticks in done wait", err_code, 0);
        tick_once();
        chk(err_code == 2'd3 && busy == 1'b0 && done_ok == 1'b0, "R5 done missing code",
            err_code, 3);

        chk(pat_err == 0, "R8 pattern over all loads", pat_err, 0);
        chk(prog_err == 0, "R9 program over all loads", prog_err, 0);
        summary();
        $finish;
    end

endmodule